// File: doc/BRIEF.md
# Central Barrier Counter Unit

This unit sits at the central node of a mesh network-on-chip, between the local processor and the network interface. It keeps a small table of barrier counters. Each counter is selected by a global barrier number. The local core arms an entry by writing the number of participants it expects. Acquire packets then arrive from the network. Each one names a barrier and carries a count, which may be more than one because routers merge acquires on the way. The unit adds that count to the running total of the named entry.

When the total reaches or passes the target, the unit clears the entry and offers one broadcast release packet to the network interface. The unit never records which nodes arrived. Two sticky flags report misuse to the core:
- an acquire that names an entry that is not armed;
- an acquire that pushes the total past the target.

Back-pressure works as follows. The acquire input is valid/ready. It is stalled (`acq_ready` low) for as long as a release is waiting. The release output is valid/ready. It holds `rel_valid` and `rel_id` steady until the interface raises `rel_ready`. An entry whose release is still waiting cannot be armed again.

Top module: `barrier_root_unit`

## Requirements
- R1: After reset the outputs are as follows: no entry busy (`busy_mask` all zero), `rel_valid` low, both error flags low, and `acq_ready` high.
- R2: An arm request is accepted, with `arm_ack` high in the same cycle, when the target is non-zero and the entry is idle. After that clock edge, the entry's `busy_mask` bit is 1 and its running count is 0.
- R3: An arm request is refused (`arm_ack` low, no state change) in two cases: the target is 0, or the entry is busy. An entry is busy while it is armed and also while its release is waiting.
- R4: An accepted acquire adds its `acq_cnt` field, which may be larger than 1, to the named entry. No release is issued while the sum stays below the target.
- R5: An accepted acquire can bring the sum to the target or beyond. When it does, the entry is cleared at that clock edge, and from the next cycle `rel_valid` is high with `rel_id` equal to the barrier number.
- R6: While `rel_valid` is high and `rel_ready` is low, `rel_valid` and `rel_id` hold their values. While `rel_valid` is high, `acq_ready` is low. The release is retired on the first cycle with `rel_ready` high.
- R7: An acquire accepted for an unarmed entry is dropped and sets `err_unarmed` from the next cycle. The flag stays set until `err_clr` is pulsed.
- R8: An acquire that makes the sum exceed the target still issues the release. It also sets `err_overshoot` from the next cycle, and that flag is sticky in the same way.
- R9: An `err_clr` pulse drops both flags after the clock edge. A new error in the same cycle as the clear wins.
- R10: Entries are independent. Acquires to one barrier do not change the count or the release timing of any other barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_req | input | 1 | Core request to arm an entry |
| arm_id | input | 3 | Barrier number to arm |
| arm_target | input | 9 | Participant count to wait for |
| arm_ack | output | 1 | Arm accepted this cycle |
| err_clr | input | 1 | Clears both error flags |
| err_unarmed | output | 1 | Sticky: acquire for unarmed entry |
| err_overshoot | output | 1 | Sticky: total passed the target |
| busy_mask | output | 8 | Per entry: armed or release waiting |
| acq_valid | input | 1 | Acquire packet present |
| acq_ready | output | 1 | Acquire accepted when high with valid |
| acq_id | input | 3 | Barrier number named by the acquire |
| acq_cnt | input | 9 | Merged participant count carried |
| rel_valid | output | 1 | Broadcast release waiting |
| rel_ready | input | 1 | Network interface takes the release |
| rel_id | output | 3 | Barrier number being released |

## Verification
A wrong running count or a lost armed bit shows at the ports within one cycle of the acquire that completes a barrier. In that cycle `rel_valid` either rises when it should not or fails to rise, so each barrier is driven to one below its target and then to the target. A stuck release or a corrupted `rel_id` is visible in the cycles while `rel_ready` is held low, when `acq_ready` must also stay low. A refused or wrongly accepted arm shows immediately on `arm_ack`, and on `busy_mask` one cycle later.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_CNT_W   = 9;

  typedef enum logic {
    OP_ARM = 1'b0,
    OP_ACQ = 1'b1
  } bar_op_e;
endpackage

// File: rtl/brc_entry.sv
module brc_entry #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_en,
  input  logic [CNT_W-1:0] arm_tgt,
  input  logic             acq_en,
  input  logic [CNT_W-1:0] acq_cnt,
  output logic             armed,
  output logic             fire,
  output logic             over
);
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   sum;

  assign sum  = {1'b0, count_q} + {1'b0, acq_cnt};
  assign fire = acq_en && armed && (sum >= {1'b0, target_q});
  assign over = fire && (sum > {1'b0, target_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      target_q <= '0;
      count_q  <= '0;
    end else if (fire) begin
      armed   <= 1'b0;
      count_q <= '0;
    end else if (acq_en && armed) begin
      count_q <= sum[CNT_W-1:0];
    end else if (arm_en) begin
      armed    <= 1'b1;
      target_q <= arm_tgt;
      count_q  <= '0;
    end
  end
endmodule

// File: rtl/brc_release.sv
module brc_release #(
  parameter int unsigned ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] load_id,
  input  logic            rel_ready,
  output logic            rel_valid,
  output logic [ID_W-1:0] rel_id
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_valid <= 1'b0;
      rel_id    <= '0;
    end else if (load) begin
      rel_valid <= 1'b1;
      rel_id    <= load_id;
    end else if (rel_valid && rel_ready) begin
      rel_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/brc_errflags.sv
module brc_errflags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_unarmed,
  input  logic set_over,
  input  logic clr,
  output logic err_unarmed,
  output logic err_overshoot
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_unarmed   <= 1'b0;
      err_overshoot <= 1'b0;
    end else begin
      err_unarmed   <= set_unarmed || (err_unarmed && !clr);
      err_overshoot <= set_over || (err_overshoot && !clr);
    end
  end
endmodule

// File: rtl/barrier_root_unit.sv
module barrier_root_unit
  import barrier_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned ID_W    = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_req,
  input  logic [ID_W-1:0]    arm_id,
  input  logic [CNT_W-1:0]   arm_target,
  output logic               arm_ack,
  input  logic               err_clr,
  output logic               err_unarmed,
  output logic               err_overshoot,
  output logic [ENTRIES-1:0] busy_mask,
  input  logic               acq_valid,
  output logic               acq_ready,
  input  logic [ID_W-1:0]    acq_id,
  input  logic [CNT_W-1:0]   acq_cnt,
  output logic               rel_valid,
  input  logic               rel_ready,
  output logic [ID_W-1:0]    rel_id
);
  logic [ENTRIES-1:0] armed_v, fire_v, over_v, arm_en_v, acq_en_v;
  logic               acq_take, fire_any, over_any, set_unarmed;
  logic [ID_W-1:0]    fire_id;

  assign acq_ready = !rel_valid;
  assign acq_take  = acq_valid && acq_ready;
  assign arm_ack   = arm_req && (arm_target != '0) && !busy_mask[arm_id];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign arm_en_v[i]  = arm_ack && (arm_id == ID_W'(i));
    assign acq_en_v[i]  = acq_take && (acq_id == ID_W'(i));
    assign busy_mask[i] = armed_v[i] || (rel_valid && rel_id == ID_W'(i));

    brc_entry #(.CNT_W(CNT_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_en  (arm_en_v[i]),
      .arm_tgt (arm_target),
      .acq_en  (acq_en_v[i]),
      .acq_cnt (acq_cnt),
      .armed   (armed_v[i]),
      .fire    (fire_v[i]),
      .over    (over_v[i])
    );
  end

  always_comb begin
    fire_id = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fire_v[i]) fire_id = ID_W'(i);
  end

  assign fire_any    = |fire_v;
  assign over_any    = |over_v;
  assign set_unarmed = acq_take && !armed_v[acq_id];

  brc_release #(.ID_W(ID_W)) u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire_any),
    .load_id   (fire_id),
    .rel_ready (rel_ready),
    .rel_valid (rel_valid),
    .rel_id    (rel_id)
  );

  brc_errflags u_err (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_unarmed   (set_unarmed),
    .set_over      (over_any),
    .clr           (err_clr),
    .err_unarmed   (err_unarmed),
    .err_overshoot (err_overshoot)
  );
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ID_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm_req,
  input logic [ID_W-1:0]    arm_id,
  input logic               arm_ack,
  input logic               err_clr,
  input logic               err_unarmed,
  input logic               err_overshoot,
  input logic [ENTRIES-1:0] busy_mask,
  input logic               acq_valid,
  input logic               acq_ready,
  input logic [ID_W-1:0]    acq_id,
  input logic               rel_valid,
  input logic               rel_ready,
  input logic [ID_W-1:0]    rel_id
);
  AST_ARM_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && busy_mask[arm_id]) |-> !arm_ack); // R3
  AST_ARM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ack |=> busy_mask[$past(arm_id)]); // R2
  AST_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_id))); // R6
  AST_ACQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> !acq_ready); // R6
  AST_UNARMED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && acq_ready && !busy_mask[acq_id]) |=> err_unarmed); // R7
  AST_UNARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_unarmed && !err_clr) |=> err_unarmed); // R7
  AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overshoot && !err_clr) |=> err_overshoot); // R8
endmodule

bind barrier_root_unit brc_checker #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .arm_req       (arm_req),
  .arm_id        (arm_id),
  .arm_ack       (arm_ack),
  .err_clr       (err_clr),
  .err_unarmed   (err_unarmed),
  .err_overshoot (err_overshoot),
  .busy_mask     (busy_mask),
  .acq_valid     (acq_valid),
  .acq_ready     (acq_ready),
  .acq_id        (acq_id),
  .rel_valid     (rel_valid),
  .rel_ready     (rel_ready),
  .rel_id        (rel_id)
);

// File: tb/barrier_root_unit_tb.sv
module barrier_root_unit_tb_top;
  import barrier_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_req = 1'b0;
  logic [2:0] arm_id = '0;
  logic [8:0] arm_target = '0;
  logic       arm_ack;
  logic       err_clr = 1'b0;
  logic       err_unarmed, err_overshoot;
  logic [7:0] busy_mask;
  logic       acq_valid = 1'b0;
  logic       acq_ready;
  logic [2:0] acq_id = '0;
  logic [8:0] acq_cnt = '0;
  logic       rel_valid;
  logic       rel_ready = 1'b0;
  logic [2:0] rel_id;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  barrier_root_unit dut_i (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .arm_id(arm_id),
    .arm_target(arm_target), .arm_ack(arm_ack), .err_clr(err_clr),
    .err_unarmed(err_unarmed), .err_overshoot(err_overshoot),
    .busy_mask(busy_mask), .acq_valid(acq_valid), .acq_ready(acq_ready),
    .acq_id(acq_id), .acq_cnt(acq_cnt), .rel_valid(rel_valid),
    .rel_ready(rel_ready), .rel_id(rel_id)
  );

  // vector: {op, id[2:0], value[8:0], expect}
  // expect = arm_ack for OP_ARM, rel_valid for OP_ACQ
  localparam int NV = 19;
  localparam logic [13:0] VEC [NV] = '{
    {OP_ARM, 3'd0, 9'd4,   1'b1},  // R2
    {OP_ACQ, 3'd0, 9'd1,   1'b0},  // R4
    {OP_ACQ, 3'd0, 9'd2,   1'b0},  // R4 merged count
    {OP_ACQ, 3'd0, 9'd1,   1'b1},  // R5 reaches target
    {OP_ARM, 3'd0, 9'd2,   1'b1},  // R2 re-arm after retire
    {OP_ARM, 3'd0, 9'd3,   1'b0},  // R3 busy
    {OP_ARM, 3'd1, 9'd0,   1'b0},  // R3 zero target
    {OP_ARM, 3'd1, 9'd3,   1'b1},  // R2
    {OP_ACQ, 3'd1, 9'd3,   1'b1},  // R5 single merged packet
    {OP_ACQ, 3'd0, 9'd2,   1'b1},  // R5
    {OP_ARM, 3'd7, 9'd256, 1'b1},  // R2 full mesh
    {OP_ACQ, 3'd7, 9'd255, 1'b0},  // R4 one below
    {OP_ACQ, 3'd7, 9'd1,   1'b1},  // R5
    {OP_ARM, 3'd4, 9'd2,   1'b1},  // R10
    {OP_ARM, 3'd6, 9'd2,   1'b1},  // R10
    {OP_ACQ, 3'd4, 9'd1,   1'b0},  // R10
    {OP_ACQ, 3'd6, 9'd1,   1'b0},  // R10
    {OP_ACQ, 3'd6, 9'd1,   1'b1},  // R10 id6 fires alone
    {OP_ACQ, 3'd4, 9'd1,   1'b1}   // R10 id4 unaffected
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input logic [2:0] id, input logic [8:0] tgt, input bit exp_ack, input string req);
    @(negedge clk);
    arm_req = 1'b1; arm_id = id; arm_target = tgt;
    #1;
    chk(arm_ack == exp_ack, req, arm_ack, exp_ack);
    @(negedge clk);
    arm_req = 1'b0;
    if (exp_ack) chk(busy_mask[id] == 1'b1, req, busy_mask[id], 1);
  endtask

  // drives one acquire, checks release; retires it when auto is set
  task automatic do_acq(input logic [2:0] id, input logic [8:0] cnt, input bit exp_rel,
                        input bit auto_ret, input string req);
    @(negedge clk);
    acq_valid = 1'b1; acq_id = id; acq_cnt = cnt;
    @(negedge clk);
    acq_valid = 1'b0;
    chk(rel_valid == exp_rel, req, rel_valid, exp_rel);
    if (exp_rel) begin
      chk(rel_id == id, req, rel_id, id);
      chk(acq_ready == 1'b0, "R6", acq_ready, 0);
      if (auto_ret) begin
        rel_ready = 1'b1;
        @(negedge clk);
        rel_ready = 1'b0;
        chk(rel_valid == 1'b0, "R6", rel_valid, 0);
        chk(busy_mask[id] == 1'b0, req, busy_mask[id], 0);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_mask == '0, "R1", busy_mask, 0);
    chk(rel_valid == 1'b0, "R1", rel_valid, 0);
    chk(err_unarmed == 1'b0 && err_overshoot == 1'b0, "R1", {err_unarmed, err_overshoot}, 0);
    chk(acq_ready == 1'b1, "R1", acq_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][13] == OP_ARM)
        do_arm(VEC[v][12:10], VEC[v][9:1], VEC[v][0], "R2/R3 vec");
      else
        do_acq(VEC[v][12:10], VEC[v][9:1], VEC[v][0], 1'b1, "R4/R5/R10 vec");
    end
    chk(err_unarmed == 1'b0 && err_overshoot == 1'b0, "R7", {err_unarmed, err_overshoot}, 0);

    // R6 held release with back-pressure; R3 re-arm refused while waiting
    do_arm(3'd3, 9'd1, 1'b1, "R2");
    do_acq(3'd3, 9'd1, 1'b1, 1'b0, "R5");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rel_valid == 1'b1 && rel_id == 3'd3, "R6", rel_id, 3);
      chk(acq_ready == 1'b0, "R6", acq_ready, 0);
    end
    do_arm(3'd3, 9'd2, 1'b0, "R3 release waiting");
    rel_ready = 1'b1;
    @(negedge clk);
    rel_ready = 1'b0;
    chk(rel_valid == 1'b0 && acq_ready == 1'b1, "R6", rel_valid, 0);

    // R7 acquire for unarmed entry
    do_acq(3'd5, 9'd1, 1'b0, 1'b1, "R7 no release");
    chk(err_unarmed == 1'b1, "R7", err_unarmed, 1);
    chk(busy_mask[5] == 1'b0, "R7", busy_mask[5], 0);
    repeat (2) @(negedge clk);
    chk(err_unarmed == 1'b1, "R7 sticky", err_unarmed, 1);

    // R9 clear
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_unarmed == 1'b0, "R9", err_unarmed, 0);

    // R8 overshoot still releases
    do_arm(3'd2, 9'd2, 1'b1, "R2");
    do_acq(3'd2, 9'd3, 1'b1, 1'b1, "R8 release");
    chk(err_overshoot == 1'b1, "R8", err_overshoot, 1);
    chk(err_unarmed == 1'b0, "R8", err_unarmed, 0);

    // R9 set beats clear in the same cycle
    @(negedge clk);
    acq_valid = 1'b1; acq_id = 3'd5; acq_cnt = 9'd1; err_clr = 1'b1;
    @(negedge clk);
    acq_valid = 1'b0; err_clr = 1'b0;
    chk(err_unarmed == 1'b1, "R9 set wins", err_unarmed, 1);
    chk(err_overshoot == 1'b0, "R9", err_overshoot, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule